// File: doc/BRIEF.md
# Integrating Over-Current Fault Timer

This block sits beside the phase or duty modulator of a bridge converter. It decides when repeated current-limit trips mean a real fault. Every trip opens a charge window that lasts until the next switching-cycle tick. While the window is open, a 16-bit fault accumulator counts up once per system clock. A trip early in the period therefore adds a lot of charge, and a late trip adds little. A hard short that trips at the start of every cycle reaches the trip level within a few periods. A load surge that trips late may never reach it. A leak counter removes one count at a programmable interval, so old events fade.

Crossing the programmable trip level starts a hiccup. The outputs are inhibited, the soft-start level drops to zero, and no new charge is taken. The outputs stay off until the leak has brought the accumulator down to a lower restart level. After that, the soft-start level climbs one step per programmable number of cycle ticks. The commanded drive is clamped to that level. A shutdown or undervoltage request also blanks the outputs and clears soft start. A sticky flag records that a hiccup has happened, and a clear strobe resets it.

The control state machine has three states: `ST_RUN` (outputs enabled), `ST_HICCUP` (fault inhibit) and `ST_OFF` (external shutdown). It has five transitions:
- *trip* moves from RUN to HICCUP when the accumulator is at or above the trip level.
- *recover* moves from HICCUP to RUN when the accumulator is at or below the restart level.
- *stop* moves from RUN or HICCUP to OFF on a shutdown request. This takes priority over the other transitions.
- *release* moves from OFF to RUN when the request drops.

Top module: `hic_fault_timer`

## Requirements
- R1: A trip while not inhibited opens the charge window at the next clock edge. A tick without a trip closes it. A trip in the same clock as a tick keeps the window open for the new period. Extra trips within one period add nothing.
- R2: Take the tick clock as index 0 of a period of P clocks. A single trip in clock i raises `fault_level` by exactly P−i once the next tick has passed, provided no leak falls in that time.
- R3: With no charge, `fault_level` falls by exactly one every `cfg_leak_div`+1 clocks. It never wraps below 0 or above 65535.
- R4: In RUN with no shutdown request and `fault_level` ≥ `cfg_trip_level`, the next state is HICCUP. In HICCUP, `out_inhibit`=1 and `fault_active`=1, and one clock later `ss_level`=0.
- R5: While the outputs are inhibited (HICCUP or OFF), `ilim_trip` adds no charge, so `fault_level` never rises.
- R6: HICCUP is held while `fault_level` > `cfg_restart_level`. It returns to RUN in the clock after `fault_level` ≤ `cfg_restart_level`.
- R7: In RUN, `ss_level` rises by one on every (`cfg_ss_div`+1)-th cycle tick and holds at 255.
- R8: `drive_limited` is the smaller of `demand` and `ss_level`, so it is 0 while `ss_level` is 0.
- R9: `shutdown_req` forces OFF at the next edge, with `out_inhibit`=1 and `ss_level`=0 one clock later. It leaves `fault_seen` unchanged. Dropping the request returns to RUN at the next edge.
- R10: `fault_seen` is set on entry to HICCUP and cleared by a one-clock `clr_fault_seen`. A set in the same clock wins over a clear.
- R11: After reset, the state is RUN and `fault_level`, `ss_level`, `drive_limited`, `fault_active` and `fault_seen` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One-clock pulse marking the start of each switching period |
| ilim_trip | input | 1 | Current-limit comparator trip |
| shutdown_req | input | 1 | Undervoltage or shutdown request |
| clr_fault_seen | input | 1 | Clear strobe for the sticky fault flag |
| cfg_trip_level | input | ACC_W | Accumulator level that starts a hiccup |
| cfg_restart_level | input | ACC_W | Accumulator level that allows restart |
| cfg_leak_div | input | LEAK_W | Leak interval minus one, in clocks |
| cfg_ss_div | input | SSDIV_W | Soft-start step interval minus one, in ticks |
| demand | input | SS_W | Commanded phase or duty |
| out_inhibit | output | 1 | Bridge outputs forced off |
| drive_limited | output | SS_W | Demand clamped to the soft-start level |
| ss_level | output | SS_W | Present soft-start limit |
| fault_level | output | ACC_W | Fault accumulator value |
| fault_active | output | 1 | High while in the hiccup state |
| fault_seen | output | 1 | Sticky record of a hiccup |

## Verification
The bench places trips at several positions in the period, including the tick clock itself and two trips in one period. A design that cleared the window on the tick regardless of a coincident trip, or that charged per trip rather than per open clock, would show a wrong charge. It runs late-trip surges that must not shut down and early-trip shorts that must. A missing or wrong leak would show up in an exact hundred-clock decrement count and in the floor at zero. During the hiccup the bench keeps tripping and watches for any rise in charge. It also watches for release below the restart level, which a design without hysteresis would allow too early or never. The soft-start step count, its saturation, the demand clamp and the shutdown path are checked directly.

// File: rtl/hic_pkg.sv
`timescale 1ns/1ps
package hic_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HICCUP = 2'd1,
        ST_OFF    = 2'd2
    } hic_state_e;

endpackage

// File: rtl/hic_trip_window.sv
`timescale 1ns/1ps
module hic_trip_window (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_tick_i,
    input  logic trip_i,
    input  logic inhibit_i,
    output logic window_o
);

    logic win_q;

    // inhibit closes, trip opens (even on a tick clock), tick closes
    always_ff @(posedge clk) begin
        if (!rst_n)         win_q <= 1'b0;
        else if (inhibit_i) win_q <= 1'b0;
        else if (trip_i)    win_q <= 1'b1;
        else if (cyc_tick_i) win_q <= 1'b0;
    end

    assign window_o = win_q;

    assert_window_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_i && !inhibit_i) |=> window_o);

    assert_window_shut_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !window_o);

endmodule

// File: rtl/hic_integrator.sv
`timescale 1ns/1ps
module hic_integrator #(
    parameter int ACC_W  = 16,
    parameter int LEAK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              charge_i,
    input  logic [LEAK_W-1:0] cfg_leak_div_i,
    output logic [ACC_W-1:0]  acc_o
);

    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};
    localparam logic [LEAK_W-1:0] LEAK_ONE = {{(LEAK_W-1){1'b0}}, 1'b1};

    logic [LEAK_W-1:0] leak_cnt_q;
    logic              leak_pulse;
    logic [ACC_W-1:0]  acc_q;
    logic              inc, dec;

    assign leak_pulse = (leak_cnt_q == cfg_leak_div_i);

    always_ff @(posedge clk) begin
        if (!rst_n)          leak_cnt_q <= '0;
        else if (leak_pulse) leak_cnt_q <= '0;
        else                 leak_cnt_q <= leak_cnt_q + LEAK_ONE;
    end

    assign inc = charge_i && (acc_q != ACC_MAX);
    assign dec = leak_pulse && (acc_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n)            acc_q <= '0;
        else if (inc && !dec)  acc_q <= acc_q + ACC_ONE;
        else if (dec && !inc)  acc_q <= acc_q - ACC_ONE;
    end

    assign acc_o = acc_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == ACC_MAX) |=> (acc_o != '0));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == '0) |=> (acc_o != ACC_MAX));

    assert_leak_only_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !charge_i |=> (acc_o <= $past(acc_o)));

endmodule

// File: rtl/hic_softstart.sv
`timescale 1ns/1ps
module hic_softstart #(
    parameter int SS_W    = 8,
    parameter int SSDIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_tick_i,
    input  logic               inhibit_i,
    input  logic [SSDIV_W-1:0] cfg_div_i,
    output logic [SS_W-1:0]    level_o
);

    localparam logic [SS_W-1:0]    LVL_MAX = {SS_W{1'b1}};
    localparam logic [SS_W-1:0]    LVL_ONE = {{(SS_W-1){1'b0}}, 1'b1};
    localparam logic [SSDIV_W-1:0] DIV_ONE = {{(SSDIV_W-1){1'b0}}, 1'b1};

    logic [SSDIV_W-1:0] tick_cnt_q;
    logic [SS_W-1:0]    level_q;

    always_ff @(posedge clk) begin
        if (!rst_n || inhibit_i) begin
            tick_cnt_q <= '0;
            level_q    <= '0;
        end else if (cyc_tick_i) begin
            if (tick_cnt_q == cfg_div_i) begin
                tick_cnt_q <= '0;
                if (level_q != LVL_MAX) level_q <= level_q + LVL_ONE;
            end else begin
                tick_cnt_q <= tick_cnt_q + DIV_ONE;
            end
        end
    end

    assign level_o = level_q;

    assert_ss_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> (level_o == '0));

    assert_ss_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_i |=> ((level_o == $past(level_o)) || (level_o == $past(level_o) + LVL_ONE)));

endmodule

// File: rtl/hic_fault_timer.sv
`timescale 1ns/1ps
module hic_fault_timer
    import hic_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int LEAK_W  = 16,
    parameter int SS_W    = 8,
    parameter int SSDIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_tick,
    input  logic               ilim_trip,
    input  logic               shutdown_req,
    input  logic               clr_fault_seen,
    input  logic [ACC_W-1:0]   cfg_trip_level,
    input  logic [ACC_W-1:0]   cfg_restart_level,
    input  logic [LEAK_W-1:0]  cfg_leak_div,
    input  logic [SSDIV_W-1:0] cfg_ss_div,
    input  logic [SS_W-1:0]    demand,
    output logic               out_inhibit,
    output logic [SS_W-1:0]    drive_limited,
    output logic [SS_W-1:0]    ss_level,
    output logic [ACC_W-1:0]   fault_level,
    output logic               fault_active,
    output logic               fault_seen
);

    hic_state_e       state_q, state_d;
    logic             inhibit;
    logic             window, charge;
    logic [ACC_W-1:0] acc;
    logic [SS_W-1:0]  level;
    logic             seen_q;
    logic             enter_hiccup;

    hic_trip_window u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_tick_i (cyc_tick),
        .trip_i     (ilim_trip),
        .inhibit_i  (inhibit),
        .window_o   (window)
    );

    assign charge = window && !inhibit;

    hic_integrator #(.ACC_W(ACC_W), .LEAK_W(LEAK_W)) u_integrator (
        .clk            (clk),
        .rst_n          (rst_n),
        .charge_i       (charge),
        .cfg_leak_div_i (cfg_leak_div),
        .acc_o          (acc)
    );

    hic_softstart #(.SS_W(SS_W), .SSDIV_W(SSDIV_W)) u_softstart (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_tick_i (cyc_tick),
        .inhibit_i  (inhibit),
        .cfg_div_i  (cfg_ss_div),
        .level_o    (level)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions: stop has priority, then trip / recover / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (shutdown_req)               state_d = ST_OFF;
                else if (acc >= cfg_trip_level) state_d = ST_HICCUP;
            end
            ST_HICCUP: begin
                if (shutdown_req)                  state_d = ST_OFF;
                else if (acc <= cfg_restart_level) state_d = ST_RUN;
            end
            ST_OFF: begin
                if (!shutdown_req) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        inhibit       = (state_q != ST_RUN);
        fault_active  = (state_q == ST_HICCUP);
        drive_limited = (demand < level) ? demand : level;
    end

    assign enter_hiccup = (state_q != ST_HICCUP) && (state_d == ST_HICCUP);

    always_ff @(posedge clk) begin
        if (!rst_n)              seen_q <= 1'b0;
        else if (enter_hiccup)   seen_q <= 1'b1;
        else if (clr_fault_seen) seen_q <= 1'b0;
    end

    assign out_inhibit = inhibit;
    assign ss_level    = level;
    assign fault_level = acc;
    assign fault_seen  = seen_q;

    assert_enter_hiccup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !shutdown_req && fault_level >= cfg_trip_level)
        |=> (out_inhibit && fault_active));

    assert_no_charge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_inhibit |=> (fault_level <= $past(fault_level)));

    assert_hold_hiccup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_active && !shutdown_req && fault_level > cfg_restart_level) |=> fault_active);

    assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_limited <= demand) && (drive_limited <= ss_level));

    assert_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> (out_inhibit && !fault_active));

    assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_active) |-> fault_seen);

endmodule

// File: tb/hic_fault_timer_tb.sv
`timescale 1ns/1ps
module hic_fault_timer_tb;

    localparam int P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0;
    logic        ilim_trip = 1'b0;
    logic        shutdown_req = 1'b0;
    logic        clr_fault_seen = 1'b0;
    logic [15:0] cfg_trip_level = 16'd1000;
    logic [15:0] cfg_restart_level = 16'd20;
    logic [15:0] cfg_leak_div = 16'hFFFF;
    logic [7:0]  cfg_ss_div = 8'd0;
    logic [7:0]  demand = 8'd0;
    logic        out_inhibit;
    logic [7:0]  drive_limited;
    logic [7:0]  ss_level;
    logic [15:0] fault_level;
    logic        fault_active;
    logic        fault_seen;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hic_fault_timer u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .cyc_tick          (cyc_tick),
        .ilim_trip         (ilim_trip),
        .shutdown_req      (shutdown_req),
        .clr_fault_seen    (clr_fault_seen),
        .cfg_trip_level    (cfg_trip_level),
        .cfg_restart_level (cfg_restart_level),
        .cfg_leak_div      (cfg_leak_div),
        .cfg_ss_div        (cfg_ss_div),
        .demand            (demand),
        .out_inhibit       (out_inhibit),
        .drive_limited     (drive_limited),
        .ss_level          (ss_level),
        .fault_level       (fault_level),
        .fault_active      (fault_active),
        .fault_seen        (fault_seen)
    );

    // trip positions (A, B; -1 = none) and expected charge per vector
    localparam int VA[6] = '{15, 10, 0, 19, 5, -1};
    localparam int VB[6] = '{-1, -1, -1, -1, 12, -1};
    localparam int VD[6] = '{5, 10, 20, 1, 15, 0};

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic trip);
        cyc_tick  = (ph == 0);
        ilim_trip = trip;
        @(posedge clk);
        #1;
        ph = (ph + 1) % P;
    endtask

    task automatic run_cycle(input int a, input int b);
        while (ph != 0) step(1'b0);
        for (int i = 0; i < P; i++) step((i == a) || (i == b));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc_tick = 1'b0; ilim_trip = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        ph = 0;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint cum;
        longint a0;
        int k;
        int n;
        bit bad;

        // R11 reset state
        do_reset();
        chk("R11 inhibit", out_inhibit, 0);
        chk("R11 fault_level", fault_level, 0);
        chk("R11 ss_level", ss_level, 0);
        chk("R11 drive_limited", drive_limited, 0);
        chk("R11 fault_active", fault_active, 0);
        chk("R11 fault_seen", fault_seen, 0);

        // R2 / R1 vector walk: charge equals clocks left in the period
        cum = 0;
        for (int v = 0; v < 6; v++) begin
            run_cycle(VA[v], VB[v]);
            run_cycle(-1, -1);
            cum += VD[v];
            chk($sformatf("R2 R1 charge vector %0d", v), fault_level, cum);
        end
        chk("R4 no trip below level", out_inhibit, 0);

        // R7 with divider 0: one step per tick, 12 ticks so far
        chk("R7 ss after 12 ticks", ss_level, 12);
        demand = 8'd200; #1;
        chk("R8 clamp to ss", drive_limited, 12);
        demand = 8'd5; #1;
        chk("R8 demand below ss", drive_limited, 5);

        // hiccup scenario
        cfg_trip_level = 16'd60; cfg_restart_level = 16'd20;
        cfg_leak_div = 16'd99; cfg_ss_div = 8'd1; demand = 8'd200;
        do_reset();
        for (int i = 0; i < 4; i++) run_cycle(15, -1);
        chk("R2 late trips no hiccup", out_inhibit, 0);
        chk("R10 no sticky yet", fault_seen, 0);
        k = 0;
        while (!out_inhibit && k < 4) begin
            run_cycle(0, -1);
            k++;
        end
        chk("R4 early trips reach hiccup", out_inhibit, 1);
        chk("R4 hiccup within 3 periods", (k <= 3), 1);
        a0 = fault_level;
        for (int i = 0; i < 3; i++) run_cycle(0, -1);
        chk("R5 no charge in hiccup", (fault_level <= a0), 1);
        chk("R4 ss cleared", ss_level, 0);
        chk("R8 drive zero when off", drive_limited, 0);
        chk("R4 fault_active", fault_active, 1);
        chk("R10 sticky set", fault_seen, 1);

        // R6 hysteresis and release
        n = 0; bad = 1'b0;
        while (out_inhibit && n < 20000) begin
            step(1'b0);
            n++;
            if (out_inhibit && fault_level < cfg_restart_level) bad = 1'b1;
        end
        chk("R6 released", out_inhibit, 0);
        chk("R6 level at release", (fault_level <= cfg_restart_level), 1);
        chk("R6 held above restart", bad, 0);

        // R7 divider 1: one step per two ticks
        for (int i = 0; i < 6; i++) run_cycle(-1, -1);
        chk("R7 ss after 6 ticks div 1", ss_level, 3);
        chk("R8 clamp after restart", drive_limited, 3);

        // R9 shutdown and R10 clear
        shutdown_req = 1'b1;
        step(1'b0); step(1'b0);
        chk("R9 inhibit on shutdown", out_inhibit, 1);
        chk("R9 ss cleared", ss_level, 0);
        chk("R9 not a fault", fault_active, 0);
        chk("R9 sticky kept", fault_seen, 1);
        clr_fault_seen = 1'b1; step(1'b0); clr_fault_seen = 1'b0;
        chk("R10 sticky cleared", fault_seen, 0);
        a0 = fault_level;
        for (int i = 0; i < P; i++) step(1'b1);
        chk("R5 no charge in shutdown", (fault_level <= a0), 1);
        chk("R10 sticky stays clear", fault_seen, 0);
        shutdown_req = 1'b0;
        step(1'b0);
        chk("R9 release to run", out_inhibit, 0);

        // R3 leak: one count per cfg_leak_div+1 clocks, floor at zero
        cfg_trip_level = 16'd1000; cfg_leak_div = 16'd9; cfg_ss_div = 8'd0;
        do_reset();
        for (int i = 0; i < 3; i++) run_cycle(0, -1);
        run_cycle(-1, -1);
        a0 = fault_level;
        chk("R3 precharge enough", (a0 >= 10), 1);
        for (int i = 0; i < 100; i++) step(1'b0);
        chk("R3 leak 10 in 100 clocks", fault_level, a0 - 10);
        for (int i = 0; i < 1000; i++) step(1'b0);
        chk("R3 floor at zero", fault_level, 0);

        // R7 saturation
        do_reset();
        for (int i = 0; i < 260; i++) run_cycle(-1, -1);
        chk("R7 ss saturates", ss_level, 255);
        demand = 8'd255; #1;
        chk("R8 full drive", drive_limited, 255);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule